// File: doc/BRIEF.md
# Morse Code Character Transmitter

This block sends one alphanumeric character as Morse code on a single keyed line. A host writes an 8-bit ASCII code into a transmit buffer. It then pulses a send command. The block looks the character up in a built-in table. It then drives the key line high for each dot or dash, with a one-unit low gap between elements. Every duration is counted in units of a tick, and the tick is the system clock divided by `DIV`.

Each character has its own number of elements, so the serial frame is a different length for each character. When the last element ends, the block raises a completion interrupt flag. The flag stays set until the host clears it. Codes the table does not hold raise an error flag instead, and nothing is keyed.

Top module: `morse_char_tx`

## Requirements
- R1: After reset, `key_out`, `busy`, `irq` and `err` are all low.
- R2: A transmission starts only on a `send` pulse while idle. It uses the character that was in the buffer before that clock edge, and `key_out` goes high from the next cycle.
- R3: Supported codes are 0x41–0x5A ('A'–'Z') and 0x30–0x39 ('0'–'9'), each keyed with its standard Morse pattern. Each entry holds an element count from 1 to 5 and a pattern, with bit value 1 = dash and 0 = dot, sent first element first.
- R4: A dot holds `key_out` high for `DIV` clock cycles. A dash holds it high for `3*DIV` cycles.
- R5: Consecutive elements are separated by exactly `DIV` cycles of low key. The key is never high while `busy` is low.
- R6: '7' (0x37) is keyed as dash, dash, dot, dot, dot, giving high runs of 48, 48, 16, 16 and 16 cycles at `DIV`=16.
- R7: On the edge where the last element ends, `key_out` falls, `busy` falls and `irq` rises, all together.
- R8: `irq` stays set until an `irq_clr` pulse or the next accepted `send` clears it. If completion and `irq_clr` fall on the same edge, `irq` ends up set.
- R9: `busy` is high from the edge after an accepted send until completion. A `send` while busy is ignored.
- R10: An unsupported code sets `err`, leaves `busy` and `key_out` low, and clears `irq`. The next accepted valid send clears `err`.
- R11: Writing the buffer during a transmission does not change the character being keyed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_wr | input | 1 | Write strobe for the transmit buffer |
| buf_data | input | 8 | ASCII code to write into the buffer |
| send | input | 1 | Send command strobe |
| irq_clr | input | 1 | Clear strobe for the completion flag |
| key_out | output | 1 | Keyed Morse line, high during an element |
| busy | output | 1 | High while a character is being keyed |
| irq | output | 1 | Transmit-complete interrupt flag |
| err | output | 1 | Set when the last send named an unsupported code |

## Verification
The assertions assume synchronous single-cycle strobes sampled at the rising clock edge. They also assume a buffer write on the same edge as a send is meant for the next character. The bench drives every strobe at the falling edge for exactly one cycle. It applies mid-transmission sends and buffer writes deliberately, to exercise the ignore rules rather than to break the assumptions. It never issues `irq_clr` and completion on the same edge, so the per-cycle model has no ordering ambiguity.

// File: rtl/morse_char_tx.sv
module morse_char_tx #(
  parameter int DIV        = 16,
  parameter int DASH_UNITS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       buf_wr,
  input  logic [7:0] buf_data,
  input  logic       send,
  input  logic       irq_clr,
  output logic       key_out,
  output logic       busy,
  output logic       irq,
  output logic       err
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam int UW = $clog2(DASH_UNITS + 1);

  logic [7:0]    buf_q;
  logic [DW-1:0] div_cnt;
  logic [UW-1:0] units;
  logic [4:0]    sh;
  logic [2:0]    left;
  logic          on;

  logic       ok;
  logic [2:0] cnt;
  logic [4:0] pat;
  logic [3:0] dig;
  logic [4:0] lsh;

  assign dig = buf_q[3:0];

  always_comb begin
    ok  = 1'b1;
    cnt = 3'd0;
    pat = 5'd0;
    if (buf_q >= 8'h30 && buf_q <= 8'h39) begin
      cnt = 3'd5;
      pat = (dig <= 4'd5) ? (5'h1f >> dig) : 5'((5'h1f << (4'd10 - dig)));
    end else begin
      case (buf_q)
        8'h41: {cnt, pat} = {3'd2, 5'b00001};
        8'h42: {cnt, pat} = {3'd4, 5'b01000};
        8'h43: {cnt, pat} = {3'd4, 5'b01010};
        8'h44: {cnt, pat} = {3'd3, 5'b00100};
        8'h45: {cnt, pat} = {3'd1, 5'b00000};
        8'h46: {cnt, pat} = {3'd4, 5'b00010};
        8'h47: {cnt, pat} = {3'd3, 5'b00110};
        8'h48: {cnt, pat} = {3'd4, 5'b00000};
        8'h49: {cnt, pat} = {3'd2, 5'b00000};
        8'h4A: {cnt, pat} = {3'd4, 5'b00111};
        8'h4B: {cnt, pat} = {3'd3, 5'b00101};
        8'h4C: {cnt, pat} = {3'd4, 5'b00100};
        8'h4D: {cnt, pat} = {3'd2, 5'b00011};
        8'h4E: {cnt, pat} = {3'd2, 5'b00010};
        8'h4F: {cnt, pat} = {3'd3, 5'b00111};
        8'h50: {cnt, pat} = {3'd4, 5'b00110};
        8'h51: {cnt, pat} = {3'd4, 5'b01101};
        8'h52: {cnt, pat} = {3'd3, 5'b00010};
        8'h53: {cnt, pat} = {3'd3, 5'b00000};
        8'h54: {cnt, pat} = {3'd1, 5'b00001};
        8'h55: {cnt, pat} = {3'd3, 5'b00001};
        8'h56: {cnt, pat} = {3'd4, 5'b00001};
        8'h57: {cnt, pat} = {3'd3, 5'b00011};
        8'h58: {cnt, pat} = {3'd4, 5'b01001};
        8'h59: {cnt, pat} = {3'd4, 5'b01011};
        8'h5A: {cnt, pat} = {3'd4, 5'b01100};
        default: ok = 1'b0;
      endcase
    end
  end

  // left-align so the first element sits in bit 4
  assign lsh = pat << (3'd5 - cnt);

  logic start, tick;
  assign start   = send && !busy;
  assign tick    = busy && (div_cnt == DW'(DIV - 1));
  assign key_out = on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q   <= 8'h00;
      div_cnt <= '0;
      units   <= '0;
      sh      <= 5'd0;
      left    <= 3'd0;
      on      <= 1'b0;
      busy    <= 1'b0;
      irq     <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (buf_wr) buf_q <= buf_data;
      if (irq_clr) irq <= 1'b0;
      if (start) begin
        irq <= 1'b0;
        if (ok) begin
          busy    <= 1'b1;
          err     <= 1'b0;
          on      <= 1'b1;
          sh      <= lsh << 1;
          units   <= lsh[4] ? UW'(DASH_UNITS) : UW'(1);
          left    <= cnt;
          div_cnt <= '0;
        end else begin
          err <= 1'b1;
        end
      end else if (tick) begin
        div_cnt <= '0;
        if (units != UW'(1)) begin
          units <= units - UW'(1);
        end else if (on) begin
          on <= 1'b0;
          if (left == 3'd1) begin
            busy <= 1'b0;
            irq  <= 1'b1;
          end else begin
            units <= UW'(1);
            left  <= left - 3'd1;
          end
        end else begin
          on    <= 1'b1;
          units <= sh[4] ? UW'(DASH_UNITS) : UW'(1);
          sh    <= sh << 1;
        end
      end else if (busy) begin
        div_cnt <= div_cnt + DW'(1);
      end
    end
  end

  a_r2_start_keys: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ok) |=> (busy && key_out)) else $error("R2 start");
  a_r4_key_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(div_cnt) != DW'(DIV - 1)) |-> $stable(key_out)) else $error("R4 key timing");
  a_r5_key_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    key_out |-> busy) else $error("R5 key without busy");
  a_r7_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (irq && !key_out)) else $error("R7 completion");
  a_r9_send_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && send && !tick) |=> busy) else $error("R9 busy send");
  a_r10_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ok) |=> (err && !busy && !key_out)) else $error("R10 bad code");
endmodule

// File: tb/morse_char_tx_tb.sv
module morse_char_tx_tb_top;
  localparam int DIV = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic buf_wr = 1'b0, send = 1'b0, irq_clr = 1'b0;
  logic [7:0] buf_data = 8'h00;
  logic key_out, busy, irq, err;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  morse_char_tx #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_data(buf_data), .send(send),
    .irq_clr(irq_clr), .key_out(key_out), .busy(busy), .irq(irq), .err(err));

  function automatic string morse_of(input logic [7:0] c);
    case (c)
      "A": return ".-";    "B": return "-...";  "C": return "-.-.";  "D": return "-..";
      "E": return ".";     "F": return "..-.";  "G": return "--.";   "H": return "....";
      "I": return "..";    "J": return ".---";  "K": return "-.-";   "L": return ".-..";
      "M": return "--";    "N": return "-.";    "O": return "---";   "P": return ".--.";
      "Q": return "--.-";  "R": return ".-.";   "S": return "...";   "T": return "-";
      "U": return "..-";   "V": return "...-";  "W": return ".--";   "X": return "-..-";
      "Y": return "-.--";  "Z": return "--..";
      "0": return "-----"; "1": return ".----"; "2": return "..---"; "3": return "...--";
      "4": return "....-"; "5": return "....."; "6": return "-...."; "7": return "--...";
      "8": return "---.."; "9": return "----.";
      default: return "";
    endcase
  endfunction

  bit mq[$];
  logic m_irq = 1'b0, m_err = 1'b0;
  logic [7:0] m_buf = 8'h00;

  always @(posedge clk) begin
    bit was;
    string s;
    if (!rst_n) begin
      mq.delete(); m_irq = 1'b0; m_err = 1'b0; m_buf = 8'h00;
    end else begin
      was = (mq.size() != 0);
      if (was) void'(mq.pop_front());
      if (irq_clr) m_irq = 1'b0;
      if (was && mq.size() == 0) m_irq = 1'b1;
      if (send && !was) begin
        m_irq = 1'b0;
        s = morse_of(m_buf);
        if (s.len() == 0) m_err = 1'b1;
        else begin
          m_err = 1'b0;
          for (int i = 0; i < s.len(); i++) begin
            for (int k = 0; k < ((s[i] == "-") ? 3 * DIV : DIV); k++) mq.push_back(1'b1);
            if (i != s.len() - 1) for (int k = 0; k < DIV; k++) mq.push_back(1'b0);
          end
        end
      end
      if (buf_wr) m_buf = buf_data;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model (R3/R4/R5/R7/R9/R10/R11)
  int run = 0;
  int runs[$];
  always @(negedge clk) begin
    logic ek;
    if (rst_n) begin
      ek = (mq.size() != 0) ? mq[0] : 1'b0;
      check(key_out == ek, "R3/R4/R5/R11 key", key_out, ek);
      check(busy == (mq.size() != 0), "R9 busy", busy, mq.size() != 0);
      check(irq == m_irq, "R7/R8 irq", irq, m_irq);
      check(err == m_err, "R10 err", err, m_err);
      if (key_out) run++;
      else if (run > 0) begin runs.push_back(run); run = 0; end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_up();
    end
  end

  task automatic pulse_wr(input logic [7:0] c);
    buf_wr = 1'b1; buf_data = c; @(negedge clk); buf_wr = 1'b0;
  endtask

  task automatic do_send(input logic [7:0] c, input bit good);
    pulse_wr(c);
    send = 1'b1;
    check(key_out == 1'b0, "R2 key before send", key_out, 0);
    @(negedge clk); send = 1'b0;
    check(key_out == good, "R2 key after send", key_out, good);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(key_out == 0 && busy == 0 && irq == 0 && err == 0, "R1 reset", {key_out, busy, irq, err}, 0);
    @(negedge clk);
    runs.delete();
    do_send("7", 1'b1);
    @(negedge clk);
    // R6: dash dash dot dot dot
    check(runs.size() == 5, "R6 element count", runs.size(), 5);
    if (runs.size() == 5) begin
      check(runs[0] == 48 && runs[1] == 48, "R6 dashes", runs[0], 48);
      check(runs[2] == 16 && runs[3] == 16 && runs[4] == 16, "R6 dots", runs[4], 16);
    end
    repeat (5) @(negedge clk);
    check(irq == 1'b1, "R8 irq held", irq, 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    check(irq == 1'b0, "R8 irq cleared", irq, 0);
    for (int i = 0; i < 26; i++) begin do_send(8'h41 + 8'(i), 1'b1); @(negedge clk); end
    for (int i = 0; i < 10; i++) begin do_send(8'h30 + 8'(i), 1'b1); @(negedge clk); end
    // R8: next accepted send clears irq without irq_clr
    check(irq == 1'b1, "R8 irq before send", irq, 1);
    do_send("#", 1'b0);
    check(err == 1'b1 && busy == 1'b0, "R10 unsupported", {err, busy}, 2);
    check(irq == 1'b0, "R8 send clears irq", irq, 0);
    repeat (20) @(negedge clk);
    check(key_out == 1'b0, "R10 nothing keyed", key_out, 0);
    do_send("a", 1'b0);
    check(err == 1'b1, "R10 lowercase", err, 1);
    // R9/R11: send and buffer write while busy
    pulse_wr("B");
    send = 1'b1; @(negedge clk); send = 1'b0;
    repeat (30) @(negedge clk);
    pulse_wr("Z");
    send = 1'b1; @(negedge clk); send = 1'b0;
    check(busy == 1'b1, "R9 still busy", busy, 1);
    check(err == 1'b0, "R10 err cleared by valid send", err, 0);
    while (busy) @(negedge clk);
    do_send("Z", 1'b1);
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule